// File: doc/BRIEF.md
# Synchronous Exception Priority Selector

This block sits at the trap point of a processor pipeline. One instruction can raise several synchronous faults at once: a fetch page fault together with an illegal opcode, or a misaligned store together with a data watchpoint. The block receives one request flag per fault class and picks exactly one winner using a fixed ranking. It turns that winner into the architectural cause number and latches the number, with the matching trap value, into a cause register and a trap-value register when the pipeline commits the trap.

The ranking does not follow the numeric cause values. Breakpoints on fetch and breakpoints on data both report cause 3, but they sit at opposite ends of the instruction/data split, so they arrive as separate flags. A misaligned control-flow target ranks below every other fetch-side fault. Environment calls report 8, 9 or 11 depending on the privilege level of the caller. One implementation-specific class ranks below all standard ones, and its number is a parameter. Selection is purely combinational. Only the two result registers are clocked.

Flag bit order, highest priority first (bit 0 is highest): 0 fetch breakpoint, 1 fetch page fault, 2 fetch access fault, 3 illegal instruction, 4 misaligned branch target, 5 environment call, 6 data breakpoint, 7 store misaligned, 8 load misaligned, 9 store page fault, 10 load page fault, 11 store access fault, 12 load access fault, 13 custom.

Top module: `sync_exc_arbiter`

## Requirements
- R1: Among fetch-side classes (flag bits 0 to 4), the lowest set bit wins, and its code is 3, 12, 1, 2 or 0 respectively.
- R2: The environment call (bit 5) outranks every data-side class. Data-side classes (bits 6 to 12) rank by bit position with codes 3, 6, 4, 15, 13, 7 and 5.
- R3: Fetch breakpoint (bit 0) and data breakpoint (bit 6) both produce code 3. With both set, the winner is the fetch breakpoint, so its trap value is the one recorded.
- R4: The environment call code follows priv_mode: 2'b00 gives 8, 2'b01 gives 9, and 2'b11 or 2'b10 gives 11.
- R5: The custom class (bit 13) wins only when no other flag is set, and its code is CUSTOM_CODE (default 24).
- R6: exc_pending equals the OR of all flags, and exc_code shows the winner's code in the same cycle the flags are applied.
- R7: At a rising edge with commit high and exc_pending high, cause_q takes the winner's code zero-extended, with its top bit (the interrupt bit) cleared.
- R8: At any edge where commit is low or no flag is set, cause_q and tval_q keep their values.
- R9: On update, tval_q takes the trap value of the winning class, except for the environment call, which records zero.
- R10: While rst_n is low, cause_q and tval_q are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_flags | input | 14 | One request flag per class, bit 0 highest priority |
| priv_mode | input | 2 | Privilege level of the instruction, used for the environment call code |
| tval_in | input | 14*XLEN | Trap value per class, class k at bits k*XLEN +: XLEN |
| commit | input | 1 | Trap commit strobe |
| exc_pending | output | 1 | At least one flag is set (combinational) |
| exc_code | output | CODE_W | Code of the winning class (combinational) |
| cause_q | output | XLEN | Cause register |
| tval_q | output | XLEN | Trap value register |

## Verification
exc_pending and exc_code are due in the same cycle as the flags. The bench applies inputs on the falling edge and reads these outputs one time step later, without waiting for a clock. cause_q and tval_q are due one rising edge after the commit. The bench folds each commit into a model value and compares the registers at the next falling edge, before it applies the next stimulus. Every pair of flags is swept under each privilege level, then random flag sets with random commits cover the hold and update paths.

// File: rtl/sync_exc_pkg.sv
package sync_exc_pkg;
  localparam int NCLS = 14;
  localparam int CODE_MAXW = 8;

  typedef enum logic [3:0] {
    C_FETCH_BKPT  = 4'd0,
    C_FETCH_PF    = 4'd1,
    C_FETCH_AF    = 4'd2,
    C_ILLEGAL     = 4'd3,
    C_TARGET_MIS  = 4'd4,
    C_ENV_CALL    = 4'd5,
    C_DATA_BKPT   = 4'd6,
    C_STORE_MIS   = 4'd7,
    C_LOAD_MIS    = 4'd8,
    C_STORE_PF    = 4'd9,
    C_LOAD_PF     = 4'd10,
    C_STORE_AF    = 4'd11,
    C_LOAD_AF     = 4'd12,
    C_CUSTOM      = 4'd13
  } exc_class_e;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } priv_e;

  function automatic logic [CODE_MAXW-1:0] class_code(
    input exc_class_e cls, input priv_e pv, input logic [CODE_MAXW-1:0] custom);
    logic [CODE_MAXW-1:0] c;
    case (cls)
      C_FETCH_BKPT: c = 8'd3;
      C_FETCH_PF:   c = 8'd12;
      C_FETCH_AF:   c = 8'd1;
      C_ILLEGAL:    c = 8'd2;
      C_TARGET_MIS: c = 8'd0;
      C_ENV_CALL: begin
        case (pv)
          PRIV_USER:  c = 8'd8;
          PRIV_SUPER: c = 8'd9;
          default:    c = 8'd11;
        endcase
      end
      C_DATA_BKPT:  c = 8'd3;
      C_STORE_MIS:  c = 8'd6;
      C_LOAD_MIS:   c = 8'd4;
      C_STORE_PF:   c = 8'd15;
      C_LOAD_PF:    c = 8'd13;
      C_STORE_AF:   c = 8'd7;
      C_LOAD_AF:    c = 8'd5;
      default:      c = custom;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/exc_prio_picker.sv
module exc_prio_picker
  import sync_exc_pkg::*;
#(
  parameter int N = NCLS
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [3:0]   win_idx,
  output logic         any
);
  localparam int IW = 4;
  logic [N:0] above;

  assign above[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]   = req[i] & ~above[i];
    assign above[i+1] = above[i] | req[i];
  end

  assign any = above[N];

  always_comb begin
    win_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) win_idx = k[IW-1:0];
    end
  end
endmodule

// File: rtl/exc_result_map.sv
module exc_result_map
  import sync_exc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CODE_W      = 6,
  parameter int CUSTOM_CODE = 24
) (
  input  logic [3:0]           win_idx,
  input  logic [1:0]           priv_mode,
  input  logic [NCLS*XLEN-1:0] tval_in,
  output logic [CODE_W-1:0]    code,
  output logic [XLEN-1:0]      tval
);
  localparam logic [CODE_MAXW-1:0] CUST = CODE_MAXW'(CUSTOM_CODE);
  logic [CODE_MAXW-1:0] wide_code;
  logic [XLEN-1:0]      tv_arr [NCLS];

  for (genvar k = 0; k < NCLS; k++) begin : g_split
    assign tv_arr[k] = tval_in[k*XLEN +: XLEN];
  end

  always_comb begin
    wide_code = class_code(exc_class_e'(win_idx), priv_e'(priv_mode), CUST);
    code      = wide_code[CODE_W-1:0];
    if (win_idx == C_ENV_CALL || win_idx >= 4'(NCLS)) tval = '0;
    else                                               tval = tv_arr[win_idx];
  end
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   tval,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   tval_q
);
  localparam int PAD = XLEN - CODE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      tval_q  <= '0;
    end else if (load) begin
      cause_q <= {{PAD{1'b0}}, code};
      tval_q  <= tval;
    end
  end
endmodule

// File: rtl/sync_exc_arbiter.sv
module sync_exc_arbiter
  import sync_exc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CODE_W      = 6,
  parameter int CUSTOM_CODE = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCLS-1:0]      exc_flags,
  input  logic [1:0]           priv_mode,
  input  logic [NCLS*XLEN-1:0] tval_in,
  input  logic                 commit,
  output logic                 exc_pending,
  output logic [CODE_W-1:0]    exc_code,
  output logic [XLEN-1:0]      cause_q,
  output logic [XLEN-1:0]      tval_q
);
  logic [NCLS-1:0] grant;
  logic [3:0]      win_idx;
  logic [XLEN-1:0] sel_tval;

  exc_prio_picker #(.N(NCLS)) u_pick (
    .req(exc_flags), .grant(grant), .win_idx(win_idx), .any(exc_pending)
  );

  exc_result_map #(.XLEN(XLEN), .CODE_W(CODE_W), .CUSTOM_CODE(CUSTOM_CODE)) u_map (
    .win_idx(win_idx), .priv_mode(priv_mode), .tval_in(tval_in),
    .code(exc_code), .tval(sel_tval)
  );

  exc_cause_reg #(.XLEN(XLEN), .CODE_W(CODE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .load(commit & exc_pending),
    .code(exc_code), .tval(sel_tval), .cause_q(cause_q), .tval_q(tval_q)
  );
endmodule

// File: rtl/sync_exc_arbiter_chk.sv
module sync_exc_arbiter_chk
  import sync_exc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCLS-1:0]   exc_flags,
  input logic [NCLS-1:0]   grant,
  input logic              commit,
  input logic              exc_pending,
  input logic [CODE_W-1:0] exc_code,
  input logic [XLEN-1:0]   cause_q,
  input logic [XLEN-1:0]   tval_q
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R1
  AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~exc_flags) == '0); // R2
  AST_PEND_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pending == (grant != '0)); // R6
  AST_LOAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && exc_pending) |=> (cause_q == XLEN'($past(exc_code)))); // R7
  AST_INT_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[XLEN-1] == 1'b0); // R7
  AST_HOLD_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && exc_pending) |=> ($stable(cause_q) && $stable(tval_q))); // R8
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (cause_q == '0 && tval_q == '0)); // R10
endmodule

bind sync_exc_arbiter sync_exc_arbiter_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_flags(exc_flags), .grant(grant),
  .commit(commit), .exc_pending(exc_pending), .exc_code(exc_code),
  .cause_q(cause_q), .tval_q(tval_q)
);

// File: tb/sync_exc_arbiter_tb.sv
module sync_exc_arbiter_tb;
  import sync_exc_pkg::*;
  localparam int CLK_P  = 10;
  localparam int XLEN   = 32;
  localparam int CODE_W = 6;
  localparam int CUST   = 24;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NCLS-1:0]      exc_flags = '0;
  logic [1:0]           priv_mode = 2'b00;
  logic [NCLS*XLEN-1:0] tval_in;
  logic                 commit = 1'b0;
  logic                 exc_pending;
  logic [CODE_W-1:0]    exc_code;
  logic [XLEN-1:0]      cause_q, tval_q;
  logic [XLEN-1:0]      tv [NCLS];

  int checks = 0, fails = 0;
  logic [XLEN-1:0] m_cause = '0, m_tval = '0;

  always #(CLK_P/2) clk = ~clk;

  always_comb for (int k = 0; k < NCLS; k++) tval_in[k*XLEN +: XLEN] = tv[k];

  sync_exc_arbiter #(.XLEN(XLEN), .CODE_W(CODE_W), .CUSTOM_CODE(CUST)) u_dut (
    .clk(clk), .rst_n(rst_n), .exc_flags(exc_flags), .priv_mode(priv_mode),
    .tval_in(tval_in), .commit(commit), .exc_pending(exc_pending),
    .exc_code(exc_code), .cause_q(cause_q), .tval_q(tval_q)
  );

  function automatic int win(input logic [NCLS-1:0] f);
    for (int k = 0; k < NCLS; k++) if (f[k]) return k;
    return -1;
  endfunction

  function automatic int code_of(input int k, input logic [1:0] p);
    int t [NCLS] = '{3, 12, 1, 2, 0, 0, 3, 6, 4, 15, 13, 7, 5, CUST};
    if (k == 5) return (p == 2'b00) ? 8 : (p == 2'b01) ? 9 : 11;
    return t[k];
  endfunction

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [NCLS-1:0] f, input logic [1:0] p, input logic c, input string req);
    int w;
    @(negedge clk);
    chk("R7 cause_q", cause_q, m_cause);
    chk("R8/R9 tval_q", tval_q, m_tval);
    exc_flags = f; priv_mode = p; commit = c;
    for (int k = 0; k < NCLS; k++) tv[k] = $urandom;
    #1;
    w = win(f);
    chk("R6 pending", XLEN'(exc_pending), XLEN'(w >= 0));
    if (w >= 0) begin
      chk(req, XLEN'(exc_code), XLEN'(code_of(w, p)));
      if (c) begin
        m_cause = XLEN'(code_of(w, p));
        m_tval  = (w == 5) ? '0 : tv[w];
      end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < NCLS; k++) tv[k] = 32'hA000_0000 + k;
    #(CLK_P * 2);
    chk("R10 reset cause", cause_q, '0);
    chk("R10 reset tval", tval_q, '0);
    @(negedge clk); rst_n = 1'b1;

    // R3: both breakpoints, fetch wins, code 3, its tval recorded
    step(14'h0041, 2'b11, 1'b1, "R3 bkpt pair");
    step(14'h0040, 2'b11, 1'b1, "R3 data bkpt alone");
    // R4: env call per privilege
    for (int p = 0; p < 4; p++) step(14'h0020, 2'(p), 1'b1, "R4 ecall code");
    // R5: custom alone and beaten by load access fault
    step(14'h2000, 2'b00, 1'b1, "R5 custom alone");
    step(14'h3000, 2'b00, 1'b1, "R5 custom below");
    // R8: commit without flags, flags without commit
    step(14'h0000, 2'b00, 1'b1, "R8 no flags");
    step(14'h0002, 2'b00, 1'b0, "R8 no commit");

    // R1/R2: every pair under each privilege
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < NCLS; i++)
        for (int j = 0; j < NCLS; j++)
          step((14'(1) << i) | (14'(1) << j), 2'(p), 1'b1,
               (i < 5 && j < 5) ? "R1 pair order" : "R2 pair order");

    // random mix
    for (int n = 0; n < 400; n++)
      step(14'($urandom) & 14'($urandom), 2'($urandom), 1'($urandom), "R2 random");

    step(14'h0000, 2'b00, 1'b0, "R8 final");
    @(negedge clk);
    chk("R7 final cause", cause_q, m_cause);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule